// File: doc/BRIEF.md
# Timebase-Selectable 16-bit Event Counter

This block is a free-running 16-bit up-counter whose increment source is chosen from eight timebase codes. The sources are the system clock, two fixed prescalers of the system clock, a timer overflow pulse from a neighbouring block, falling edges on an external pin, and two slow oscillator inputs that are each divided by eight. Software sees the counter as two byte registers. A read of the low byte captures the high byte, so a low-then-high read pair gives one consistent 16-bit sample while the counter keeps running.

A mode register holds the timebase code, an interrupt enable, an idle-hold control and a sticky overflow flag. The counter sets the flag when it wraps from 0xFFFF to 0x0000. The interrupt request follows the flag while the interrupt is enabled. When the idle-hold control is set and the processor signals idle, counting stops. All asynchronous inputs are brought into the system clock domain before they are used.

Top module: `pca_timebase_top`

## Requirements
- R1: After reset the count and the high-byte snapshot are 0, every mode field is 0 and `irqReq` is low.
- R2: Register addresses: 0 reads the live low byte, 1 reads the high-byte snapshot, 2 reads and writes the mode byte, laid out as bit 7 overflow flag, bit 6 idle-hold, bits 5:4 read as 0, bits 3:1 timebase code, bit 0 interrupt enable.
- R3: A read of address 0 copies the current high byte into the snapshot. Reads of address 1 return the snapshot and never the live high byte, so a low-then-high pair returns one coherent 16-bit value.
- R4: Reads of any address and writes to addresses 0 and 1 do not change or stall the count.
- R5: Timebase code 100 advances the count by one on every system clock cycle.
- R6: Code 000 advances once every 12 system clocks and code 001 once every 4 system clocks, each from a prescaler that runs freely from reset.
- R7: Code 010 advances once per single-cycle pulse on `t0Ovf`.
- R8: Code 011 advances once per high-to-low transition of `extCountPin` after a two-flop synchronizer. Rising edges do not count, and edge rates up to one in four system clocks are all counted.
- R9: Code 101 advances once per 8 synchronized rising edges of `extOscIn`. Code 110 does the same for `rtcOscIn`, using a divider of its own.
- R10: Code 111 produces no count.
- R11: A wrap from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until software writes the mode byte with bit 7 at 0. Writing 1 to bit 7 leaves the flag unchanged. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R12: `irqReq` is high exactly while the overflow flag and the interrupt enable are both 1.
- R13: With idle-hold at 1 and `cpuIdle` high the count holds. With idle-hold at 0 the count runs regardless of `cpuIdle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Register read data, valid in the cycle of the read strobe |
| t0Ovf | input | 1 | Single-cycle timer overflow pulse |
| extCountPin | input | 1 | Asynchronous external count pin |
| extOscIn | input | 1 | Asynchronous external oscillator signal |
| rtcOscIn | input | 1 | Asynchronous real-time-clock oscillator signal |
| cpuIdle | input | 1 | Processor idle indication |
| irqReq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is the wrap from 0xFFFF to 0x0000, because the count can only be moved by its timebase and cannot be loaded. The bench selects the every-cycle timebase and runs for up to one full 65,536-cycle period, polling `irqReq`. In the first cycle the request shows, it reads both count bytes and expects zero. It then exercises the rules for keeping, masking and clearing the flag. The oscillator dividers are checked with edge counts that are multiples of eight, and those inputs are left still until their own test, so each divider starts from a known phase.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LOW  = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_MODE = 2'd2
  } regAddr_e;

  typedef enum logic [2:0] {
    TB_DIV12 = 3'b000,
    TB_DIV4  = 3'b001,
    TB_T0    = 3'b010,
    TB_PIN   = 3'b011,
    TB_SYS   = 3'b100,
    TB_XOSC  = 3'b101,
    TB_RTC   = 3'b110,
    TB_NONE  = 3'b111
  } timebase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic snapLoad;
  } dpStrobe_t;
endpackage

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
  parameter int STAGES    = 2,
  parameter bit FALLING   = 1'b0,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic edgePulse
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {(STAGES + 1){RESET_VAL}};
    else       pipe <= {pipe[STAGES-1:0], asyncIn};
  end

  generate
    if (FALLING) begin : gFall
      assign edgePulse = pipe[STAGES] & ~pipe[STAGES-1];
    end else begin : gRise
      assign edgePulse = ~pipe[STAGES] & pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pca_prescale.sv
module pca_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (advance) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign tick = advance && (phase == LAST);
endmodule

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [2:0]        wrTimebase,
  input  logic              wrIrqEn,
  input  logic              wrIdleHold,
  input  logic              wrFlag,
  input  logic              regRdEn,
  input  logic              t0Ovf,
  input  logic              extCountPin,
  input  logic              extOscIn,
  input  logic              rtcOscIn,
  input  logic              cpuIdle,
  input  logic              wrapEvent,
  output dpStrobe_t         strobe,
  output logic [BYTE_W-1:0] modeByte,
  output logic              irqReq
);
  timebase_e tbSel;
  logic      irqEn;
  logic      idleHold;
  logic      ovfFlag;
  logic      modeWr;

  logic slowTick, fastTick, pinFall;
  logic [1:0] oscRaw, oscEdge, oscTick;
  logic srcTick;

  assign modeWr = regWrEn && (regAddr == ADDR_MODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbSel    <= TB_DIV12;
      irqEn    <= 1'b0;
      idleHold <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (modeWr) begin
        tbSel    <= timebase_e'(wrTimebase);
        irqEn    <= wrIrqEn;
        idleHold <= wrIdleHold;
      end
      if (wrapEvent)             ovfFlag <= 1'b1;
      else if (modeWr && !wrFlag) ovfFlag <= 1'b0;
    end
  end

  pca_prescale #(.DIV(SLOW_DIV)) uSlow (
    .clk(clk), .rstN(rstN), .advance(1'b1), .tick(slowTick)
  );
  pca_prescale #(.DIV(FAST_DIV)) uFast (
    .clk(clk), .rstN(rstN), .advance(1'b1), .tick(fastTick)
  );

  pca_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1), .RESET_VAL(1'b1)) uPin (
    .clk(clk), .rstN(rstN), .asyncIn(extCountPin), .edgePulse(pinFall)
  );

  assign oscRaw = {rtcOscIn, extOscIn};

  generate
    for (genvar g = 0; g < 2; g++) begin : gOsc
      pca_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0), .RESET_VAL(1'b0)) uSync (
        .clk(clk), .rstN(rstN), .asyncIn(oscRaw[g]), .edgePulse(oscEdge[g])
      );
      pca_prescale #(.DIV(OSC_DIV)) uDiv (
        .clk(clk), .rstN(rstN), .advance(oscEdge[g]), .tick(oscTick[g])
      );
    end
  endgenerate

  always_comb begin
    case (tbSel)
      TB_DIV12: srcTick = slowTick;
      TB_DIV4:  srcTick = fastTick;
      TB_T0:    srcTick = t0Ovf;
      TB_PIN:   srcTick = pinFall;
      TB_SYS:   srcTick = 1'b1;
      TB_XOSC:  srcTick = oscTick[0];
      TB_RTC:   srcTick = oscTick[1];
      default:  srcTick = 1'b0;
    endcase
  end

  assign strobe.countEn  = srcTick && !(idleHold && cpuIdle);
  assign strobe.snapLoad = regRdEn && (regAddr == ADDR_LOW);

  assign modeByte = {ovfFlag, idleHold, 2'b00, tbSel, irqEn};
  assign irqReq   = ovfFlag && irqEn;
endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] snapHigh,
  output logic              wrapEvent
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      snapHigh <= '0;
    end else begin
      if (strobe.countEn)  count    <= count + 1'b1;
      if (strobe.snapLoad) snapHigh <= count[CNT_W-1:BYTE_W];
    end
  end

  assign wrapEvent = strobe.countEn && (&count);
endmodule

// File: rtl/pca_timebase_top.sv
module pca_timebase_top
  import pca_pkg::*;
#(
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        regRdEn,
  output logic [7:0]  regRdData,
  input  logic        t0Ovf,
  input  logic        extCountPin,
  input  logic        extOscIn,
  input  logic        rtcOscIn,
  input  logic        cpuIdle,
  output logic        irqReq
);
  dpStrobe_t         dpStrobe;
  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] snapHigh;
  logic [BYTE_W-1:0] modeByte;
  logic              wrapEvent;
  logic [1:0]        unusedWrBits;

  assign unusedWrBits = regWrData[5:4];

  pca_ctrl #(
    .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV),
    .OSC_DIV(OSC_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn),
    .wrTimebase(regWrData[3:1]), .wrIrqEn(regWrData[0]),
    .wrIdleHold(regWrData[6]), .wrFlag(regWrData[7]),
    .regRdEn(regRdEn), .t0Ovf(t0Ovf), .extCountPin(extCountPin),
    .extOscIn(extOscIn), .rtcOscIn(rtcOscIn), .cpuIdle(cpuIdle),
    .wrapEvent(wrapEvent), .strobe(dpStrobe), .modeByte(modeByte),
    .irqReq(irqReq)
  );

  pca_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(dpStrobe),
    .count(count), .snapHigh(snapHigh), .wrapEvent(wrapEvent)
  );

  always_comb begin
    case (regAddr)
      ADDR_LOW:  regRdData = count[BYTE_W-1:0];
      ADDR_HIGH: regRdData = snapHigh;
      ADDR_MODE: regRdData = modeByte;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk
  import pca_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input dpStrobe_t         strobe,
  input logic [CNT_W-1:0]  count,
  input logic [BYTE_W-1:0] snapHigh,
  input logic [BYTE_W-1:0] modeByte,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic              wrFlag,
  input logic              regRdEn,
  input logic              cpuIdle
);
  logic ovfFlag, idleHold;
  logic [2:0] tbCode;
  assign ovfFlag  = modeByte[7];
  assign idleHold = modeByte[6];
  assign tbCode   = modeByte[3:1];

  // R4: no enable, no movement
  p_hold_no_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countEn |=> $stable(count));

  // R5: each enable advances by exactly one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |=> (count == CNT_W'($past(count) + 1'b1)));

  // R11: a wrap always leaves the flag set
  p_wrap_sets_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && (&count)) |=> ovfFlag);

  // R11: the flag only falls after a clearing write
  p_flag_clear_by_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(regWrEn && (regAddr == 2'd2) && !wrFlag));

  // R3: low-byte read captures the high byte
  p_snapshot_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (regAddr == 2'd0)) |=> (snapHigh == $past(count[CNT_W-1:BYTE_W])));

  // R3: snapshot holds without a low-byte read
  p_snapshot_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && (regAddr == 2'd0)) |=> $stable(snapHigh));

  // R13: idle-hold freezes the count
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIdle && idleHold) |=> $stable(count));

  // R10: reserved code never counts
  p_reserved_still_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tbCode == 3'b111) |=> $stable(count));
endmodule

bind pca_timebase_top pca_timebase_chk uChk (
  .clk(clk), .rstN(rstN), .strobe(dpStrobe), .count(count),
  .snapHigh(snapHigh), .modeByte(modeByte), .regAddr(regAddr),
  .regWrEn(regWrEn), .wrFlag(regWrData[7]), .regRdEn(regRdEn),
  .cpuIdle(cpuIdle)
);

// File: tb/test_pca_timebase_top.sv
module test_pca_timebase_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       t0Ovf = 1'b0;
  logic       extCountPin = 1'b1;
  logic       extOscIn = 1'b0;
  logic       rtcOscIn = 1'b0;
  logic       cpuIdle = 1'b0;
  logic       irqReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
    bit         isIrq;
  } sbItem_t;

  sbItem_t sbQ[$];
  event    sampleEv;
  sbItem_t curItem;
  logic [7:0] observed;

  always #4 clk = ~clk;

  pca_timebase_top i_pca_timebase_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .t0Ovf(t0Ovf), .extCountPin(extCountPin), .extOscIn(extOscIn),
    .rtcOscIn(rtcOscIn), .cpuIdle(cpuIdle), .irqReq(irqReq)
  );

  // Monitor: pops the expected item and compares with what the design shows
  always @(sampleEv) begin
    checks++;
    if (sbQ.size() == 0) begin
      failures++;
      $display("FAIL scoreboard empty actual=%h expected=item", regRdData);
    end else begin
      curItem  = sbQ.pop_front();
      observed = curItem.isIrq ? {7'b0, irqReq} : regRdData;
      if (observed !== curItem.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", curItem.tag, observed, curItem.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readRaw(input logic [1:0] a, output logic [7:0] v);
    regAddr = a; regRdEn = 1'b1;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    sbItem_t it;
    it.exp = exp; it.tag = tag; it.isIrq = 1'b0;
    sbQ.push_back(it);
    regAddr = a; regRdEn = 1'b1;
    #1 ->sampleEv;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectIrq(input logic exp, input string tag);
    sbItem_t it;
    it.exp = {7'b0, exp}; it.tag = tag; it.isIrq = 1'b1;
    sbQ.push_back(it);
    #1 ->sampleEv;
    #1;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [7:0] modeVal(input logic [2:0] tb, input logic en,
                                          input logic idle, input logic flag);
    return {flag, idle, 2'b00, tb, en};
  endfunction

  // Relative check: low byte advances by 'inc' over 'win' cycles
  task automatic windowCheck(input int win, input logic [7:0] inc, input string tag);
    logic [7:0] v0;
    readRaw(2'd0, v0);
    tick(win - 1);
    expectRead(2'd0, v0 + inc, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v0, lo1, hi1, lo2;
    logic [15:0] base;
    bit seen;

    tick(3);
    rstN = 1'b1;

    // R1 reset state
    expectIrq(1'b0, "R1 irq after reset");
    expectRead(2'd0, 8'h00, "R1 low after reset");
    expectRead(2'd1, 8'h00, "R1 snapshot after reset");
    expectRead(2'd2, 8'h00, "R1 mode after reset");

    // R5 every-cycle timebase, R2 mode readback
    writeReg(2'd2, modeVal(3'b100, 1'b0, 1'b0, 1'b0));
    tick(2);
    expectRead(2'd2, 8'h08, "R2 mode readback");
    windowCheck(10, 8'd10, "R5 sysclk count");

    // R4 back-to-back reads and ignored writes to count bytes
    readRaw(2'd0, v0);
    expectRead(2'd0, v0 + 8'd1, "R4 read no disturb a");
    expectRead(2'd0, v0 + 8'd2, "R4 read no disturb b");
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h00);
    expectRead(2'd0, v0 + 8'd5, "R4 writes to count ignored");

    // R3 coherent snapshot
    readRaw(2'd0, lo1);
    readRaw(2'd1, hi1);
    tick(300);
    expectRead(2'd1, hi1, "R3 snapshot holds without low read");
    readRaw(2'd0, lo2);
    base = {hi1, lo1} + 16'd303;
    checkEq("R3 low after interval", {8'h00, lo2}, {8'h00, base[7:0]});
    expectRead(2'd1, base[15:8], "R3 coherent high byte");

    // R6 prescalers
    writeReg(2'd2, modeVal(3'b001, 1'b0, 1'b0, 1'b0));
    tick(2);
    windowCheck(40, 8'd10, "R6 div4 count");
    writeReg(2'd2, modeVal(3'b000, 1'b0, 1'b0, 1'b0));
    tick(2);
    windowCheck(120, 8'd10, "R6 div12 count");

    // R10 reserved
    writeReg(2'd2, modeVal(3'b111, 1'b0, 1'b0, 1'b0));
    tick(2);
    windowCheck(50, 8'd0, "R10 reserved code still");

    // R7 timer overflow pulses
    writeReg(2'd2, modeVal(3'b010, 1'b0, 1'b0, 1'b0));
    tick(2);
    readRaw(2'd0, v0);
    for (int i = 0; i < 7; i++) begin
      t0Ovf = 1'b1; tick(1);
      t0Ovf = 1'b0; tick(2);
    end
    tick(2);
    expectRead(2'd0, v0 + 8'd7, "R7 timer pulses counted");

    // R8 falling edges on the pin, at the fastest supported rate too
    writeReg(2'd2, modeVal(3'b011, 1'b0, 1'b0, 1'b0));
    tick(2);
    readRaw(2'd0, v0);
    for (int i = 0; i < 5; i++) begin
      extCountPin = 1'b0; tick(3);
      extCountPin = 1'b1; tick(3);
    end
    for (int i = 0; i < 4; i++) begin
      extCountPin = 1'b0; tick(2);
      extCountPin = 1'b1; tick(2);
    end
    tick(5);
    expectRead(2'd0, v0 + 8'd9, "R8 pin falling edges");

    // R9 oscillator sources divided by eight
    writeReg(2'd2, modeVal(3'b101, 1'b0, 1'b0, 1'b0));
    tick(2);
    readRaw(2'd0, v0);
    for (int i = 0; i < 24; i++) begin
      extOscIn = 1'b1; tick(2);
      extOscIn = 1'b0; tick(2);
    end
    tick(5);
    expectRead(2'd0, v0 + 8'd3, "R9 external osc div8");
    writeReg(2'd2, modeVal(3'b110, 1'b0, 1'b0, 1'b0));
    tick(2);
    readRaw(2'd0, v0);
    for (int i = 0; i < 16; i++) begin
      rtcOscIn = 1'b1; tick(2);
      rtcOscIn = 1'b0; tick(2);
    end
    tick(5);
    expectRead(2'd0, v0 + 8'd2, "R9 rtc osc div8");

    // R13 idle handling
    writeReg(2'd2, modeVal(3'b100, 1'b0, 1'b0, 1'b0));
    cpuIdle = 1'b1;
    tick(2);
    windowCheck(10, 8'd10, "R13 idle without hold runs");
    writeReg(2'd2, modeVal(3'b100, 1'b0, 1'b1, 1'b0));
    tick(2);
    windowCheck(10, 8'd0, "R13 idle with hold stops");
    cpuIdle = 1'b0;
    tick(2);
    windowCheck(10, 8'd10, "R13 hold without idle runs");

    // R11 / R12 overflow
    writeReg(2'd2, modeVal(3'b100, 1'b1, 1'b0, 1'b0));
    seen = 1'b0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (irqReq) begin
        seen = 1'b1;
        break;
      end
    end
    checkEq("R11 overflow reached", {15'b0, seen}, 16'd1);
    expectRead(2'd0, 8'h00, "R11 low zero at wrap");
    expectRead(2'd1, 8'h00, "R11 high zero at wrap");
    expectRead(2'd2, 8'h89, "R11 flag set");
    tick(20);
    expectRead(2'd2, 8'h89, "R11 flag sticky");
    expectIrq(1'b1, "R12 irq with flag and enable");
    writeReg(2'd2, modeVal(3'b100, 1'b0, 1'b0, 1'b1));
    expectIrq(1'b0, "R12 irq masked");
    expectRead(2'd2, 8'h88, "R11 writing one keeps flag");
    writeReg(2'd2, modeVal(3'b100, 1'b1, 1'b0, 1'b1));
    expectIrq(1'b1, "R12 irq re-enabled");
    writeReg(2'd2, modeVal(3'b100, 1'b1, 1'b0, 1'b0));
    expectIrq(1'b0, "R11 irq after clear");
    expectRead(2'd2, 8'h09, "R11 flag cleared by zero");

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule